// File: doc/BRIEF.md
# Two-Wire Bus Unjam Sequencer

This block sits beside a two-wire bus controller and frees the bus when a target is left holding the data line low, for example after a transfer was cut short, a power drop or a reset. One request starts a sequence. The sequencer toggles the clock line at a programmed rate and checks the data line near the end of each high phase. When it sees the data line released, it stops clocking. It then drives a START condition followed by a STOP condition, which leaves every target on the bus idle.

Both bus lines are open-drain with external pull-ups. The block therefore only has output enables: a 1 on an enable pulls that line low, and a 0 releases it. The block reads both lines back through already-synchronised inputs. Readback of the clock line lets a target stretch the clock. The low phase and the high phase are each set by their own length input, counted in system clocks. The block has control and status pins only and no data stream, so none of its pins use a valid/ready handshake.

Top module: `bus_unjam`

## Requirements
- R1: After a request is accepted, `scl_oe_o` is 1 for exactly max(`low_len_i`,1) clocks in each pulse and is then released. A length of 0 acts as 1.
- R2: A high phase counts only those clocks in which `scl_i` reads 1, so a target that stretches the clock extends the phase. The phase ends after max(`high_len_i`,1) counted clocks. `sda_i` is sampled in the last counted clock.
- R3: Clocking stops after the first pulse whose sample shows `sda_i` = 1. The block never issues more than 9 pulses in one sequence.
- R4: After a release is seen, `sda_oe_o` is 1 for max(`high_len_i`,1) clocks while SCL stays released, which forms a START. SDA is then released while SCL is high, which forms a STOP. That released state is held for another max(`high_len_i`,1) clocks before the sequence completes.
- R5: If the sample of the ninth pulse still shows `sda_i` = 0, no START or STOP is generated and both enables return to 0. `fail_o` goes to 1 and stays there until the next accepted request clears it in the cycle of acceptance.
- R6: `done_o` is a single-clock pulse at the end of every sequence, whether it succeeded or failed. With P pulses and S stretched clocks in total, it rises P·(L+H)+S clocks after the accepting edge, plus 2H on success, where L and H are the effective lengths.
- R7: `start_i` is ignored while a sequence is running. It neither restarts nor extends the sequence, and it does not queue a later one.
- R8: After reset both enables, `done_o` and `fail_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery request, taken only when idle |
| low_len_i | input | CW | SCL low phase length in clocks (0 acts as 1) |
| high_len_i | input | CW | SCL high phase, START and STOP hold length in clocks (0 acts as 1) |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| done_o | output | 1 | One-clock end-of-sequence pulse |
| fail_o | output | 1 | SDA still held after the last pulse |

## Verification
The assertions assume that `scl_i` reads high within a bounded time once the clock line is released. They also assume that targets change SDA only while SCL is low, and that both length inputs stay fixed while a sequence runs. The bench builds its bus model so that it keeps within these limits. A target model releases SDA only on a falling edge of SCL, after a chosen number of pulses. A stretching model holds SCL low for a fixed number of clocks after each release. The length inputs are changed only between sequences. The sweep covers release counts from 0 to 10, which includes the ninth-pulse boundary on both sides, and it covers zero and non-zero phase lengths with and without stretching.

// File: rtl/unjam_pkg.sv
package unjam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_STA,
    ST_STO
  } unjam_state_e;
endpackage

// File: rtl/unjam_timer.sv
// Phase timer: counts enabled clocks and flags the last one of a phase.
module unjam_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_eff;

  assign len_eff = (len == '0) ? CW'(1) : len;
  assign last    = en && (cnt_q >= len_eff - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (en)     cnt_q <= last ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/unjam_pulse_ctr.sv
// Counts completed SCL pulses; flags the final permitted one.
module unjam_pulse_ctr #(
  parameter int MAXP = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic at_last
);
  localparam int PW = $clog2(MAXP + 1);
  logic [PW-1:0] cnt_q;

  assign at_last = (cnt_q == PW'(MAXP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/bus_unjam.sv
module bus_unjam
  import unjam_pkg::*;
#(
  parameter int CW   = 8,
  parameter int MAXP = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] low_len_i,
  input  logic [CW-1:0] high_len_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          done_o,
  output logic          fail_o
);
  unjam_state_e  state_q, state_d;
  logic          tmr_clear, tmr_en, tmr_last;
  logic [CW-1:0] tmr_len;
  logic          pc_clear, pc_inc, pc_at_last;
  logic          done_d, fail_d, fail_q, done_q;
  logic          busy;

  assign busy      = (state_q != ST_IDLE);
  assign scl_oe_o  = (state_q == ST_LOW);
  assign sda_oe_o  = (state_q == ST_STA);
  assign done_o    = done_q;
  assign fail_o    = fail_q;

  assign tmr_clear = (state_q == ST_IDLE);
  assign tmr_en    = (state_q == ST_HIGH) ? scl_i : busy;
  assign tmr_len   = (state_q == ST_LOW) ? low_len_i : high_len_i;
  assign pc_clear  = (state_q == ST_IDLE);
  assign pc_inc    = (state_q == ST_HIGH) && tmr_last;

  unjam_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .en    (tmr_en),
    .len   (tmr_len),
    .last  (tmr_last)
  );

  unjam_pulse_ctr #(.MAXP(MAXP)) u_pulses (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (pc_clear),
    .inc     (pc_inc),
    .at_last (pc_at_last)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    fail_d  = fail_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_LOW;
        fail_d  = 1'b0;
      end
      ST_LOW:  if (tmr_last) state_d = ST_HIGH;
      ST_HIGH: if (tmr_last) begin
        if (sda_i) begin
          state_d = ST_STA;
        end else if (pc_at_last) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
          done_d  = 1'b1;
        end else begin
          state_d = ST_LOW;
        end
      end
      ST_STA:  if (tmr_last) state_d = ST_STO;
      ST_STO:  if (tmr_last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end
endmodule

// File: rtl/bus_unjam_chk.sv
module bus_unjam_chk #(
  parameter int MAXP = 9
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic scl_oe,
  input logic sda_oe,
  input logic scl_i,
  input logic done,
  input logic fail
);
  localparam int KW = $clog2(MAXP + 2);
  logic [KW-1:0] pulses_q;
  logic          oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulses_q <= '0;
      oe_q     <= 1'b0;
    end else begin
      oe_q <= scl_oe;
      if (!busy)                 pulses_q <= '0;
      else if (scl_oe && !oe_q)  pulses_q <= pulses_q + KW'(1);
    end
  end

  a_r3_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= KW'(MAXP));

  a_r4_start_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_i);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_fail_released: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!busy && !scl_oe && !sda_oe));

  a_r8_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
endmodule

bind bus_unjam bus_unjam_chk #(.MAXP(MAXP)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .scl_oe (scl_oe_o),
  .sda_oe (sda_oe_o),
  .scl_i  (scl_i),
  .done   (done_o),
  .fail   (fail_o)
);

// File: tb/bus_unjam_tb.sv
`timescale 1ns/1ps
module bus_unjam_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] low_len = 8'd1;
  logic [7:0] high_len = 8'd1;
  logic       scl_oe, sda_oe, done, fail;
  logic       scl_line, sda_line;

  int checks = 0;
  int errors = 0;
  int k_cfg = 0;
  int s_cfg = 0;
  int l_eff = 1;
  int sc = 1000;
  int falls = 0;
  int sta_cnt = 0, sto_cnt = 0, pulses = 0, cur_low = 0, lowbad = 0;
  logic clr = 1'b0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign scl_line = !scl_oe && (sc >= s_cfg);
  assign sda_line = !sda_oe && (falls >= k_cfg);

  bus_unjam u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .low_len_i(low_len), .high_len_i(high_len),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .done_o(done), .fail_o(fail)
  );

  // clock-stretching target: counts clocks since SCL was released
  always @(posedge clk) begin
    if (scl_oe) sc <= 0;
    else if (sc < 1000) sc <= sc + 1;
  end

  // bus monitor
  always @(negedge clk) begin
    if (clr) begin
      falls <= 0; sta_cnt <= 0; sto_cnt <= 0; pulses <= 0;
      cur_low <= 0; lowbad <= 0;
      prev_scl <= scl_line; prev_sda <= sda_line; prev_oe <= scl_oe;
    end else begin
      if (prev_scl && !scl_line) falls <= falls + 1;
      if (scl_line && prev_scl && prev_sda && !sda_line) sta_cnt <= sta_cnt + 1;
      if (scl_line && prev_scl && !prev_sda && sda_line) sto_cnt <= sto_cnt + 1;
      if (scl_oe && !prev_oe) pulses <= pulses + 1;
      if (scl_oe) cur_low <= cur_low + 1;
      else begin
        if (prev_oe && cur_low != l_eff) lowbad <= lowbad + 1;
        cur_low <= 0;
      end
      prev_scl <= scl_line; prev_sda <= sda_line; prev_oe <= scl_oe;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (K=%0d L=%0d H=%0d S=%0d)",
               req, act, exp, k_cfg, low_len, high_len, s_cfg);
    end
  endtask

  task automatic run(input int k, input int l, input int h, input int s);
    int heff, p, n, cyc;
    bit succ;
    k_cfg = k; s_cfg = s;
    low_len = 8'(l); high_len = 8'(h);
    l_eff = (l == 0) ? 1 : l;
    heff  = (h == 0) ? 1 : h;
    succ  = (k <= 9);
    p     = (k <= 1) ? 1 : ((k <= 9) ? k : 9);
    n     = p * (l_eff + heff + s) + (succ ? 2 * heff : 0);
    @(posedge clk); #1 clr = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1 clr = 1'b0;
    start = 1'b1;
    cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      start = (cyc == 3);
      if (cyc == 1) chk(fail == 1'b0, "R5 fail cleared on accept", int'(fail), 0);
      if (done || cyc > 5000) break;
    end
    start = 1'b0;
    chk(cyc == 1 + n, "R2/R6 done latency", cyc, 1 + n);
    chk(fail == !succ, "R5 fail flag", int'(fail), int'(!succ));
    chk(!scl_oe && !sda_oe, "R5 lines released at end", int'({scl_oe, sda_oe}), 0);
    @(negedge clk);
    chk(pulses == p, "R3 pulse count", pulses, p);
    chk(sta_cnt == (succ ? 1 : 0), "R4 START count", sta_cnt, succ ? 1 : 0);
    chk(sto_cnt == (succ ? 1 : 0), "R4 STOP count", sto_cnt, succ ? 1 : 0);
    chk(lowbad == 0, "R1 low phase width", lowbad, 0);
    @(posedge clk); #1;
    chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      if (scl_oe || done) break;
    end
    chk(!scl_oe && !done, "R7 mid-run request ignored", int'({scl_oe, done}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!scl_oe && !sda_oe && !done && !fail, "R8 reset state",
        int'({scl_oe, sda_oe, done, fail}), 0);
    rst_n = 1'b1;
    for (int s = 0; s <= 2; s += 2)
      for (int l = 0; l <= 3; l++)
        for (int h = 0; h <= 3; h += (h == 1) ? 2 : 1)
          for (int k = 0; k <= 10; k++)
            run(k, l, h, s);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule